// File: doc/BRIEF.md
# Transition-Timeout Loss-of-Signal and Holdover Selector

This block sits behind the data slicer of a serial receiver. It sees one already-sampled bit per sample strobe and looks for transitions. When no transition has been seen for a programmable number of strobes, it raises an active-high loss-of-signal flag. The flag is released only after transitions have stayed present for a second, longer programmable number of strobes. Having two separate limits gives hysteresis, so the flag does not chatter on a marginal input.

The same block also drives the receiver's path selection. A 2-bit select picks one of three sources for the clock-recovery loop: the main data input, a loopback data input, or a reference clock used for holdover. A one-bit ratio select tells the feedback divider to divide the oscillator by 16 while the loop tracks the reference clock, and by 1 otherwise. Holdover can be requested directly by a control input. When the automatic option is enabled, the block's own loss-of-signal flag requests holdover as well, so the loop falls back to the reference on its own when data stops.

Top module: `los_holdover_sel`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `los` is 1, `path_sel` is 2'b00 and `fb_div16` is 0.
- R2: An edge is a strobed sample that differs from the previous strobed sample. The first strobe after reset is never an edge. Cycles with `smp_vld` low change no detector state, even when `smp_bit` moves in those cycles.
- R3: With `los` low, `los` rises at the clock edge of the ASSERT_CNT-th consecutive strobe without an edge after the last edge, and not earlier.
- R4: A strobe is live when fewer than ASSERT_CNT strobes without an edge have followed the last edge, counting that strobe. With `los` high, `los` falls at the clock edge of the DEASSERT_CNT-th consecutive live strobe. A strobe that is not live starts the count again.
- R5: The counters saturate. An arbitrarily long stretch without edges keeps `los` high and never wraps back to low.
- R6: The `path_sel` encoding is 2'b00 for the main input, 2'b01 for the loopback input and 2'b10 for the reference holdover path. When holdover is not requested, `loop_sel` low gives 2'b00 and `loop_sel` high gives 2'b01.
- R7: When `ref_lock` is 1, `path_sel` is 2'b10 and `fb_div16` is 1, whatever `loop_sel` is. In every other case `fb_div16` is 0.
- R8: When `auto_hold` is 1, a high `los` requests holdover exactly as `ref_lock` does. When `auto_hold` is 0, `los` has no effect on `path_sel` or `fb_div16`.
- R9: `path_sel` and `fb_div16` are registered. They show the effect of their inputs one clock edge after those inputs change, and not before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Sample strobe qualifying `smp_bit` |
| smp_bit | input | 1 | Sliced data bit |
| loop_sel | input | 1 | Choose the loopback input as data |
| ref_lock | input | 1 | Request holdover on the reference clock |
| auto_hold | input | 1 | Let `los` request holdover |
| los | output | 1 | Loss-of-signal flag, active high |
| path_sel | output | 2 | Source select: 00 main, 01 loopback, 10 reference |
| fb_div16 | output | 1 | Feedback divider ratio: 1 = divide by 16, 0 = divide by 1 |

## Verification
The embedded properties assume that `smp_vld` and `smp_bit` are sampled at the rising clock edge and that the control inputs are clean synchronous levels. The saturation and stability properties also assume that the counters leave reset at their defined values. The bench drives every input on the falling edge. It also flips `smp_bit` during cycles with the strobe low, so the properties that say idle cycles hold state actually see idle-cycle activity. It uses small limits (ASSERT_CNT 8, DEASSERT_CNT 20), which makes it practical to sweep every gap length up to and beyond the assert limit.

// File: rtl/los_sel_pkg.sv
// Shared encodings for the loss-of-signal and holdover selector.
package los_sel_pkg;
    // Source selection for the clock-recovery loop.
    typedef enum logic [1:0] {
        PATH_MAIN = 2'b00,
        PATH_LOOP = 2'b01,
        PATH_REF  = 2'b10
    } path_e;
endpackage

// File: rtl/los_edge_det.sv
// Transition finder.
// Compares each strobed bit with the previous strobed bit. The history is
// cleared by reset, so the first strobe afterwards can never count as an edge.
// Assumes smp_vld and smp_bit are synchronous to clk.
module los_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic bit_in,
    output logic edge_seen
);
    logic prev_q;
    logic hist_q;

    // An edge is a strobed sample that differs from a valid previous sample.
    assign edge_seen = stb && hist_q && (bit_in != prev_q);

    // Capture the sample history on strobes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            hist_q <= 1'b0;
        end else if (stb) begin
            prev_q <= bit_in;
            hist_q <= 1'b1;
        end
    end

    // R2: no edge is reported while the history is still empty.
    a_r2_no_edge_before_history: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !hist_q) |-> !edge_seen);
endmodule

// File: rtl/los_timer.sv
// Loss-of-signal timer with hysteresis.
// A quiet counter holds the number of strobes without an edge since the last
// edge and saturates at ASSERT_CNT, which means "no recent edge". A run
// counter holds consecutive live strobes while the flag is high. After reset
// the flag is high and the quiet counter is already saturated.
module los_timer #(
    parameter int unsigned ASSERT_CNT   = 4096,
    parameter int unsigned DEASSERT_CNT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic edge_seen,
    output logic los
);
    localparam int unsigned QW = $clog2(ASSERT_CNT + 1);
    localparam int unsigned DW = $clog2(DEASSERT_CNT + 1);
    localparam logic [QW-1:0] Q_SAT  = QW'(ASSERT_CNT);
    localparam logic [DW-1:0] R_LAST = DW'(DEASSERT_CNT - 1);

    logic [QW-1:0] quiet_q, quiet_d;
    logic [DW-1:0] run_q, run_d;
    logic          los_q, los_d;
    logic          live;

    // Next-state logic; all state moves only on a strobe.
    always_comb begin
        quiet_d = quiet_q;
        run_d   = run_q;
        los_d   = los_q;
        live    = 1'b0;
        if (stb) begin
            if (edge_seen)
                quiet_d = '0;
            else if (quiet_q != Q_SAT)
                quiet_d = quiet_q + 1'b1;
            live = (quiet_d != Q_SAT);
            if (!los_q) begin
                if (!live) begin
                    los_d = 1'b1;
                    run_d = '0;
                end
            end else if (!live) begin
                run_d = '0;
            end else if (run_q == R_LAST) begin
                los_d = 1'b0;
                run_d = '0;
            end else begin
                run_d = run_q + 1'b1;
            end
        end
    end

    // State registers; reset starts in loss-of-signal with no recent edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quiet_q <= Q_SAT;
            run_q   <= '0;
            los_q   <= 1'b1;
        end else begin
            quiet_q <= quiet_d;
            run_q   <= run_d;
            los_q   <= los_d;
        end
    end

    assign los = los_q;

    // R3: the ASSERT_CNT-th quiet strobe raises the flag.
    a_r3_quiet_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && !edge_seen && !los_q && quiet_q == QW'(ASSERT_CNT - 1)) |=> los_q);
    // R2: an edge restarts the quiet count.
    a_r2_edge_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stb && edge_seen) |=> (quiet_q == '0));
    // R2: idle cycles hold all detector state.
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !stb |=> ($stable(quiet_q) && $stable(run_q) && $stable(los_q)));
    // R4: the flag only falls on a strobe.
    a_r4_fall_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(los_q) |-> $past(stb));
    // R5: counters stay inside their saturation limits.
    a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet_q <= Q_SAT) && (run_q <= R_LAST));
endmodule

// File: rtl/los_path_reg.sv
// Registered source and divider selection.
// Holdover is requested by ref_lock, or by the loss-of-signal flag when
// auto_hold is set. Holdover wins over loopback. Outputs update on clk only.
module los_path_reg
    import los_sel_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       loop_sel,
    input  logic       ref_lock,
    input  logic       auto_hold,
    input  logic       los,
    output logic [1:0] path_sel,
    output logic       fb_div16
);
    logic  hold_req;
    path_e path_d;
    path_e path_q;
    logic  div_q;

    // Combine the explicit and automatic holdover requests.
    assign hold_req = ref_lock || (auto_hold && los);

    // Priority: holdover, then loopback, then main input.
    always_comb begin
        if (hold_req)      path_d = PATH_REF;
        else if (loop_sel) path_d = PATH_LOOP;
        else               path_d = PATH_MAIN;
    end

    // Output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            path_q <= PATH_MAIN;
            div_q  <= 1'b0;
        end else begin
            path_q <= path_d;
            div_q  <= hold_req;
        end
    end

    assign path_sel = path_q;
    assign fb_div16 = div_q;

    // R7: explicit holdover forces the reference path and divide-by-16.
    a_r7_ref_forces: assert property (@(posedge clk) disable iff (!rst_n)
        ref_lock |=> (path_sel == PATH_REF && fb_div16));
    // R6: loopback without holdover selects the loopback input at divide-by-1.
    a_r6_loopback: assert property (@(posedge clk) disable iff (!rst_n)
        (!ref_lock && !(auto_hold && los) && loop_sel) |=> (path_sel == PATH_LOOP && !fb_div16));
    // R8: the flag requests holdover when the automatic option is on.
    a_r8_auto_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_hold && los) |=> (path_sel == PATH_REF));
    // R6: at most one source code bit is set.
    a_r6_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(path_sel));
endmodule

// File: rtl/los_holdover_sel.sv
// Top level: transition finder, loss-of-signal timer and path register.
// Assumes that data arrives already sliced, one bit per strobe, on clk.
module los_holdover_sel #(
    parameter int unsigned ASSERT_CNT   = 4096,
    parameter int unsigned DEASSERT_CNT = 10000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_vld,
    input  logic       smp_bit,
    input  logic       loop_sel,
    input  logic       ref_lock,
    input  logic       auto_hold,
    output logic       los,
    output logic [1:0] path_sel,
    output logic       fb_div16
);
    logic edge_seen;
    logic los_int;

    los_edge_det u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_vld),
        .bit_in    (smp_bit),
        .edge_seen (edge_seen)
    );

    los_timer #(
        .ASSERT_CNT   (ASSERT_CNT),
        .DEASSERT_CNT (DEASSERT_CNT)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (smp_vld),
        .edge_seen (edge_seen),
        .los       (los_int)
    );

    los_path_reg u_path (
        .clk       (clk),
        .rst_n     (rst_n),
        .loop_sel  (loop_sel),
        .ref_lock  (ref_lock),
        .auto_hold (auto_hold),
        .los       (los_int),
        .path_sel  (path_sel),
        .fb_div16  (fb_div16)
    );

    assign los = los_int;

    // R1: flag is high in the first cycle out of reset.
    a_r1_reset_flag: assert property (@(posedge clk)
        $rose(rst_n) |-> los);
endmodule

// File: tb/los_holdover_sel_bench.sv
`timescale 1ns/1ps
module los_holdover_sel_bench;
    localparam int unsigned A = 8;
    localparam int unsigned D = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_vld = 1'b0;
    logic       smp_bit = 1'b0;
    logic       loop_sel = 1'b0;
    logic       ref_lock = 1'b0;
    logic       auto_hold = 1'b0;
    logic       los;
    logic [1:0] path_sel;
    logic       fb_div16;

    int  n_vec  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic cur   = 1'b0;

    always #2 clk = ~clk;

    los_holdover_sel #(.ASSERT_CNT(A), .DEASSERT_CNT(D)) u_los_holdover_sel (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
        .loop_sel(loop_sel), .ref_lock(ref_lock), .auto_hold(auto_hold),
        .los(los), .path_sel(path_sel), .fb_div16(fb_div16)
    );

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One strobed sample; outputs are read 1 ns after the capturing edge.
    task automatic strobe(input logic b);
        @(negedge clk);
        smp_vld = 1'b1;
        smp_bit = b;
        @(posedge clk);
        #1;
        smp_vld = 1'b0;
    endtask

    // Idle cycle with the data pin moving but no strobe.
    task automatic idle_flip();
        @(negedge clk);
        smp_vld = 1'b0;
        smp_bit = ~smp_bit;
        @(posedge clk);
        #1;
    endtask

    // D toggling strobes: los must stay high until the D-th.
    task automatic relock(input string req);
        for (int i = 1; i <= int'(D); i++) begin
            cur = ~cur;
            strobe(cur);
            check(req, int'(los), (i < int'(D)) ? 1 : 0);
        end
    endtask

    function automatic int exp_path(input logic r, input logic l, input logic a, input logic f);
        if (r || (a && f)) return 2;
        if (l) return 1;
        return 0;
    endfunction

    initial begin
        // R1: reset state.
        repeat (3) @(posedge clk);
        #1;
        check("R1 los", int'(los), 1);
        check("R1 path_sel", int'(path_sel), 0);
        check("R1 fb_div16", int'(fb_div16), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 los after release", int'(los), 1);

        // R5: a long stretch of constant data keeps los high.
        for (int i = 0; i < 3 * int'(A); i++) begin
            strobe(1'b0);
            idle_flip();
        end
        check("R5 los saturated", int'(los), 1);

        // R2/R4: first strobe after reset (value 1) is not an edge; then D toggles.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur = 1'b1;
        strobe(cur);
        check("R2 first strobe no edge", int'(los), 1);
        relock("R4 deassert after D live strobes");

        // R3: sweep gap lengths, with idle cycles flipping the pin (R2).
        for (int g = 1; g <= int'(A) + 2; g++) begin
            cur = ~cur;
            strobe(cur);
            for (int j = 1; j <= g; j++) begin
                idle_flip();
                strobe(cur);
                check("R3 assert timing", int'(los), (j >= int'(A)) ? 1 : 0);
            end
            if (g >= int'(A)) relock("R4 relock after gap");
        end

        // R4: a non-live strobe restarts the deassert run.
        for (int i = 0; i < int'(A); i++) strobe(cur);
        check("R3 los high before restart test", int'(los), 1);
        for (int i = 0; i < 5; i++) begin cur = ~cur; strobe(cur); end
        for (int i = 0; i < int'(A); i++) strobe(cur);
        check("R4 run interrupted", int'(los), 1);
        relock("R4 run restarted");

        // R6/R7/R8/R9: all control combinations with los low and high.
        for (int ls = 0; ls < 2; ls++) begin
            if (ls == 1) begin
                for (int i = 0; i < int'(A); i++) strobe(cur);
            end
            check("R8 los state", int'(los), ls);
            @(negedge clk);
            ref_lock = 1'b0; loop_sel = 1'b0; auto_hold = 1'b0;
            @(posedge clk);
            #1;
            begin
                int prev_p;
                prev_p = 0;
                for (int c = 0; c < 8; c++) begin
                    int ep;
                    @(negedge clk);
                    ref_lock  = c[2];
                    loop_sel  = c[1];
                    auto_hold = c[0];
                    ep = exp_path(c[2], c[1], c[0], ls[0]);
                    #1;
                    check("R9 path held before edge", int'(path_sel), prev_p);
                    @(posedge clk);
                    #1;
                    check("R6/R8 path_sel", int'(path_sel), ep);
                    check("R7 fb_div16", int'(fb_div16), (ep == 2) ? 1 : 0);
                    prev_p = ep;
                end
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            n_vec++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule